// File: doc/BRIEF.md
# FIFO Threshold Offset Programming Unit

This block keeps the two threshold offsets that a dual-clock FIFO of depth DEPTH uses for its near-empty and near-full indications: the empty offset `empty_off` and the full offset `full_off`. While master reset is held, three strap inputs are sampled on every clock: the access-select pin `ld_sel` and the two-bit `fsel`. Together they choose one of eight default offsets, and both offsets are loaded with that default. The level of `ld_sel` alone also fixes the loading method for the rest of the session. High selects serial loading and low selects parallel loading.

After reset, `ld_sel` selects the target of the access strobes. When it is high, the write and read strobes pass through to the FIFO storage. When it is low, they address the offset registers. Offsets can then be reloaded at any time through the loading path chosen at reset. They can be read back in either mode, and only through the parallel output bus.

The FIFO array and the flag comparators live outside this block and consume `empty_off` and `full_off`.

Top module: `fifo_ofs_prog`

## Requirements
- R1: While `mrst` is high, both offsets load the default selected by {ld_sel, fsel[1], fsel[0]} as follows: 100→1023, 010→511, 001→255, 000→127, 011→63, 110→31, 101→15, 111→7. A default above DEPTH-1 is clamped to DEPTH-1.
- R2: `serial_mode` takes the level of `ld_sel` sampled during reset (1 = serial loading, 0 = parallel loading). It holds that value until the next reset.
- R3: In parallel mode, with `ld_sel` low, each clock with `wr_en` high stores `pdata_in[PW-1:0]` (PW = log2 DEPTH) into the empty offset, then into the full offset, alternating. Bits above PW-1 are ignored.
- R4: In serial mode, with `ld_sel` low, each clock with `ser_en` high shifts `ser_in` into the 2·PW-bit word {full, empty}, least significant bit first. The offsets change only on the clock that delivers the 2·PW-th bit.
- R5: The loading path that was not selected has no effect. In serial mode `wr_en` changes no offset, and in parallel mode `ser_en` changes no offset.
- R6: With `ld_sel` low, each clock with `rd_en` high places the empty offset, then the full offset (alternating), zero-extended on `pdata_out` one clock later, with `rd_valid` high for that clock. This works in both modes. A read in the same clock as a write returns the value from before the write.
- R7: With `ld_sel` high, the offsets are not accessed, and `fifo_wr_en`/`fifo_rd_en` follow `wr_en`/`rd_en`. With `ld_sel` low, or during reset, both pass-through enables are 0.
- R8: Master reset returns the parallel write and read ordering to the empty offset and discards any partially shifted serial bits.
- R9: `pdata_out` holds its value and `rd_valid` is 0 on every clock after a clock with no offset read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, synchronous, active high; straps sampled while high |
| ld_sel | input | 1 | Strap during reset; afterwards 1 = FIFO access, 0 = offset access |
| fsel | input | 2 | Default-offset select straps |
| wr_en | input | 1 | Write strobe (FIFO write or parallel offset load) |
| rd_en | input | 1 | Read strobe (FIFO read or offset readback) |
| pdata_in | input | DATA_W | Parallel load data |
| ser_in | input | 1 | Serial load data bit |
| ser_en | input | 1 | Serial shift enable |
| pdata_out | output | DATA_W | Offset readback data |
| rd_valid | output | 1 | Readback data valid |
| empty_off | output | log2(DEPTH) | Current empty offset |
| full_off | output | log2(DEPTH) | Current full offset |
| serial_mode | output | 1 | Loading method latched at reset |
| fifo_wr_en | output | 1 | Write enable passed to FIFO storage |
| fifo_rd_en | output | 1 | Read enable passed to FIFO storage |

## Verification
All eight strap combinations are applied under reset, and each must produce a distinct default. This separates a swapped or misdecoded strap bit. Parallel loading is tried with back-to-back writes, with data that has upper bits set, and with reads that collide with writes. These patterns expose a wrong order, a missing truncation and a read-after-write hazard. Serial loading is tried with full 2·PW-bit words, with a word cut short by reset, and with strobes from the other path mixed in. This tells bit-order and early-commit faults apart from leakage between paths. A long random phase toggles `ld_sel` so that the pass-through gating is covered.

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;

  typedef enum logic {MODE_PAR = 1'b0, MODE_SER = 1'b1} ld_mode_e;

  // log2 of (default offset + 1) for a given strap triple
  function automatic int unsigned strap_exp(input logic sel, input logic [1:0] fs);
    case ({sel, fs})
      3'b100:  strap_exp = 10;
      3'b010:  strap_exp = 9;
      3'b001:  strap_exp = 8;
      3'b000:  strap_exp = 7;
      3'b011:  strap_exp = 6;
      3'b110:  strap_exp = 5;
      3'b101:  strap_exp = 4;
      default: strap_exp = 3;
    endcase
  endfunction

  // Default offset clamped to the counter width (max DEPTH-1)
  function automatic logic [31:0] strap_offset(input int unsigned e, input int unsigned pw);
    logic [31:0] v;
    if (e >= pw) v = (32'd1 << pw) - 32'd1;
    else         v = (32'd1 << e) - 32'd1;
    return v;
  endfunction

endpackage

// File: rtl/fifo_ofs_strap.sv
module fifo_ofs_strap
  import fifo_ofs_pkg::*;
#(
  parameter int PW = 10
) (
  input  logic          ld_sel,
  input  logic [1:0]    fsel,
  output logic [PW-1:0] def_val,
  output ld_mode_e      def_mode
);
  logic [31:0] full_word;

  always_comb begin
    full_word = strap_offset(strap_exp(ld_sel, fsel), PW);
    def_val   = full_word[PW-1:0];
    def_mode  = ld_sel ? MODE_SER : MODE_PAR;
  end

  if (PW < 32) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^full_word[31:PW];
  end
endmodule

// File: rtl/fifo_ofs_par_load.sv
module fifo_ofs_par_load #(
  parameter int PW     = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  output logic              wr_empty,
  output logic              wr_full,
  output logic [PW-1:0]     value
);
  logic tgt_full;

  always_ff @(posedge clk) begin
    if (mrst)      tgt_full <= 1'b0;
    else if (load) tgt_full <= ~tgt_full;
  end

  assign wr_empty = load && !tgt_full;
  assign wr_full  = load && tgt_full;
  assign value    = data[PW-1:0];

  if (DATA_W > PW) begin : g_drop
    logic unused_upper;
    assign unused_upper = ^data[DATA_W-1:PW];
  end
endmodule

// File: rtl/fifo_ofs_ser_load.sv
module fifo_ofs_ser_load #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          shift,
  input  logic          bit_in,
  output logic          commit,
  output logic [PW-1:0] new_empty,
  output logic [PW-1:0] new_full
);
  localparam int SW = 2 * PW;
  localparam int CW = $clog2(SW + 1);

  logic [SW-1:0] stage_q;
  logic [SW-1:0] stage_nx;
  logic [CW-1:0] cnt_q;

  assign stage_nx = {bit_in, stage_q[SW-1:1]};
  assign commit   = shift && (cnt_q == CW'(SW - 1));

  always_ff @(posedge clk) begin
    if (mrst) begin
      stage_q <= '0;
      cnt_q   <= '0;
    end else if (shift) begin
      stage_q <= stage_nx;
      cnt_q   <= commit ? '0 : cnt_q + 1'b1;
    end
  end

  assign new_empty = stage_nx[PW-1:0];
  assign new_full  = stage_nx[SW-1:PW];
endmodule

// File: rtl/fifo_ofs_readback.sv
module fifo_ofs_readback #(
  parameter int PW     = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              rd,
  input  logic [PW-1:0]     empty_val,
  input  logic [PW-1:0]     full_val,
  output logic [DATA_W-1:0] dout,
  output logic              valid
);
  logic src_full;

  always_ff @(posedge clk) begin
    if (mrst) begin
      src_full <= 1'b0;
      dout     <= '0;
      valid    <= 1'b0;
    end else begin
      valid <= rd;
      if (rd) begin
        dout     <= DATA_W'(src_full ? full_val : empty_val);
        src_full <= ~src_full;
      end
    end
  end
endmodule

// File: rtl/fifo_ofs_prog.sv
module fifo_ofs_prog
  import fifo_ofs_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       mrst,
  input  logic                       ld_sel,
  input  logic [1:0]                 fsel,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [DATA_W-1:0]          pdata_in,
  input  logic                       ser_in,
  input  logic                       ser_en,
  output logic [DATA_W-1:0]          pdata_out,
  output logic                       rd_valid,
  output logic [$clog2(DEPTH)-1:0]   empty_off,
  output logic [$clog2(DEPTH)-1:0]   full_off,
  output logic                       serial_mode,
  output logic                       fifo_wr_en,
  output logic                       fifo_rd_en
);
  localparam int PW = $clog2(DEPTH);

  ld_mode_e      mode_q;
  ld_mode_e      def_mode;
  logic [PW-1:0] def_val;
  logic          ofs_access;
  logic          par_load, par_wr_empty, par_wr_full, par_wr;
  logic [PW-1:0] par_val;
  logic          ser_shift, ser_commit;
  logic [PW-1:0] ser_empty, ser_full;
  logic          ofs_rd;

  assign ofs_access = !mrst && !ld_sel;
  assign par_load   = ofs_access && wr_en && (mode_q == MODE_PAR);
  assign ser_shift  = ofs_access && ser_en && (mode_q == MODE_SER);
  assign ofs_rd     = ofs_access && rd_en;
  assign par_wr     = par_wr_empty || par_wr_full;

  fifo_ofs_strap #(.PW(PW)) u_strap (
    .ld_sel(ld_sel), .fsel(fsel), .def_val(def_val), .def_mode(def_mode)
  );

  fifo_ofs_par_load #(.PW(PW), .DATA_W(DATA_W)) u_par (
    .clk(clk), .mrst(mrst), .load(par_load), .data(pdata_in),
    .wr_empty(par_wr_empty), .wr_full(par_wr_full), .value(par_val)
  );

  fifo_ofs_ser_load #(.PW(PW)) u_ser (
    .clk(clk), .mrst(mrst), .shift(ser_shift), .bit_in(ser_in),
    .commit(ser_commit), .new_empty(ser_empty), .new_full(ser_full)
  );

  fifo_ofs_readback #(.PW(PW), .DATA_W(DATA_W)) u_rb (
    .clk(clk), .mrst(mrst), .rd(ofs_rd), .empty_val(empty_off),
    .full_val(full_off), .dout(pdata_out), .valid(rd_valid)
  );

  always_ff @(posedge clk) begin
    if (mrst) begin
      mode_q    <= def_mode;
      empty_off <= def_val;
      full_off  <= def_val;
    end else if (ser_commit) begin
      empty_off <= ser_empty;
      full_off  <= ser_full;
    end else begin
      if (par_wr_empty) empty_off <= par_val;
      if (par_wr_full)  full_off  <= par_val;
    end
  end

  assign serial_mode = (mode_q == MODE_SER);
  assign fifo_wr_en  = !mrst && ld_sel && wr_en;
  assign fifo_rd_en  = !mrst && ld_sel && rd_en;
endmodule

// File: rtl/fifo_ofs_prog_chk.sv
module fifo_ofs_prog_chk #(
  parameter int PW     = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              mrst,
  input logic              ld_sel,
  input logic              rd_en,
  input logic [DATA_W-1:0] pdata_out,
  input logic              rd_valid,
  input logic [PW-1:0]     empty_off,
  input logic [PW-1:0]     full_off,
  input logic              serial_mode,
  input logic              par_wr,
  input logic              ser_shift,
  input logic              ser_commit
);
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (mrst)
    !mrst |=> $stable(serial_mode));

  p_no_access_r7: assert property (@(posedge clk) disable iff (mrst)
    ld_sel |=> $stable(empty_off) && $stable(full_off));

  p_ser_partial_r4: assert property (@(posedge clk) disable iff (mrst)
    !ser_commit && !par_wr |=> $stable(empty_off) && $stable(full_off));

  p_par_only_r5: assert property (@(posedge clk) disable iff (mrst)
    par_wr |-> !serial_mode && !ser_shift);

  p_ser_only_r5: assert property (@(posedge clk) disable iff (mrst)
    ser_shift |-> serial_mode);

  p_rd_valid_r6: assert property (@(posedge clk) disable iff (mrst)
    rd_en && !ld_sel |=> rd_valid);

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (mrst)
    !(rd_en && !ld_sel) |=> $stable(pdata_out) && !rd_valid);
endmodule

bind fifo_ofs_prog fifo_ofs_prog_chk #(.PW(PW), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .mrst(mrst), .ld_sel(ld_sel), .rd_en(rd_en),
  .pdata_out(pdata_out), .rd_valid(rd_valid), .empty_off(empty_off),
  .full_off(full_off), .serial_mode(serial_mode), .par_wr(par_wr),
  .ser_shift(ser_shift), .ser_commit(ser_commit)
);

// File: tb/fifo_ofs_prog_test.sv
module fifo_ofs_prog_test;
  localparam int DEPTH  = 1024;
  localparam int DATA_W = 16;
  localparam int PW     = 10;

  logic clk = 1'b0;
  logic mrst, ld_sel, wr_en, rd_en, ser_in, ser_en;
  logic [1:0] fsel;
  logic [DATA_W-1:0] pdata_in;
  logic [DATA_W-1:0] pdata_out;
  logic rd_valid, serial_mode, fifo_wr_en, fifo_rd_en;
  logic [PW-1:0] empty_off, full_off;

  always #10 clk = ~clk;

  fifo_ofs_prog #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uut (
    .clk(clk), .mrst(mrst), .ld_sel(ld_sel), .fsel(fsel), .wr_en(wr_en),
    .rd_en(rd_en), .pdata_in(pdata_in), .ser_in(ser_in), .ser_en(ser_en),
    .pdata_out(pdata_out), .rd_valid(rd_valid), .empty_off(empty_off),
    .full_off(full_off), .serial_mode(serial_mode), .fifo_wr_en(fifo_wr_en),
    .fifo_rd_en(fifo_rd_en)
  );

  int checks = 0, failures = 0, cycles = 0;
  bit chk_on = 0, done = 0;

  // reference model state
  int defaults [8];
  int m_empty, m_full, m_pout;
  bit m_ser, m_wptr, m_rptr, m_valid;
  bit sbits[$];

  initial begin
    defaults[3'b100] = 1023; defaults[3'b010] = 511;
    defaults[3'b001] = 255;  defaults[3'b000] = 127;
    defaults[3'b011] = 63;   defaults[3'b110] = 31;
    defaults[3'b101] = 15;   defaults[3'b111] = 7;
  end

  always @(posedge clk) begin
    cycles++;
    if (mrst) begin
      m_ser = ld_sel;
      m_empty = defaults[{ld_sel, fsel}];
      m_full = m_empty;
      m_wptr = 0; m_rptr = 0; m_valid = 0; m_pout = 0;
      sbits.delete();
    end else begin
      m_valid = 0;
      if (!ld_sel && rd_en) begin
        m_pout = m_rptr ? m_full : m_empty;
        m_rptr = !m_rptr;
        m_valid = 1;
      end
      if (!ld_sel && !m_ser && wr_en) begin
        if (m_wptr) m_full = pdata_in % DEPTH;
        else        m_empty = pdata_in % DEPTH;
        m_wptr = !m_wptr;
      end
      if (!ld_sel && m_ser && ser_en) begin
        sbits.push_back(ser_in);
        if (sbits.size() == 2 * PW) begin
          m_empty = 0; m_full = 0;
          for (int i = 0; i < PW; i++) begin
            m_empty += int'(sbits[i]) << i;
            m_full  += int'(sbits[PW + i]) << i;
          end
          sbits.delete();
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check("R1/R3/R4/R5/R8 empty_off", int'(empty_off), m_empty);
      check("R1/R3/R4/R5/R8 full_off", int'(full_off), m_full);
      check("R2 serial_mode", int'(serial_mode), int'(m_ser));
      check("R6/R9 pdata_out", int'(pdata_out), m_pout);
      check("R6/R9 rd_valid", int'(rd_valid), int'(m_valid));
      check("R7 fifo_wr_en", int'(fifo_wr_en), int'(!mrst && ld_sel && wr_en));
      check("R7 fifo_rd_en", int'(fifo_rd_en), int'(!mrst && ld_sel && rd_en));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; ser_en = 0; ser_in = 0; pdata_in = '0;
  endtask

  task automatic do_reset(bit s, logic [1:0] f);
    idle(); mrst = 1; ld_sel = s; fsel = f;
    tick(2);
    mrst = 0; ld_sel = 0;
  endtask

  task automatic pwrite(int v);
    wr_en = 1; pdata_in = DATA_W'(v); tick(); wr_en = 0;
  endtask

  task automatic pread();
    rd_en = 1; tick(); rd_en = 0;
  endtask

  task automatic shift_word(int e, int f, int nbits);
    logic [2*PW-1:0] w;
    w = {PW'(f), PW'(e)};
    for (int i = 0; i < nbits; i++) begin
      ser_en = 1; ser_in = w[i]; tick();
    end
    ser_en = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog: actual=hung expected=completion");
    finish_run();
  end

  initial begin
    idle(); mrst = 1; ld_sel = 1; fsel = 2'b00;
    @(posedge clk); #1 chk_on = 1;
    tick();
    // R1 R2: every strap combination
    for (int k = 0; k < 8; k++) begin
      do_reset(k[2], k[1:0]);
      tick(2);
      check("R1 default value", int'(empty_off), defaults[k]);
    end
    // R3 R5 R6: parallel mode
    do_reset(0, 2'b00);
    pwrite(5); pwrite(900);
    pwrite(16'hFC03);            // R3: upper bits dropped
    check("R3 truncated load", int'(empty_off), 3);
    ser_en = 1; ser_in = 1; tick(25); ser_en = 0;  // R5 ignored
    pread(); pread(); pread(); tick(3);
    rd_en = 1; wr_en = 1; pdata_in = 16'd77; tick(); idle(); tick();  // R6 collision
    // R7: pass-through
    ld_sel = 1; wr_en = 1; rd_en = 1; pdata_in = 16'd12; tick(4); idle(); ld_sel = 0;
    // R8: ordering restarts at reset
    pwrite(40); do_reset(0, 2'b11); pwrite(41); pread(); tick();
    // R4 R5: serial mode
    do_reset(1, 2'b11);
    wr_en = 1; pdata_in = 16'd99; tick(3); idle();  // R5 ignored
    shift_word(300, 700, 2 * PW - 1); tick(2);
    check("R4 partial word not visible", int'(full_off), 7);
    shift_word(0, 1023, 1); tick();
    shift_word(1, 512, 2 * PW); pread(); pread(); tick(2);
    // R8: partial serial bits discarded
    shift_word(5, 6, 7); do_reset(1, 2'b00); shift_word(123, 456, 2 * PW); tick(2);
    check("R8 serial restart", int'(full_off), 456);
    // random phase
    for (int r = 0; r < 4; r++) begin
      do_reset(r[0], 2'($urandom));
      for (int i = 0; i < 400; i++) begin
        ld_sel = ($urandom % 4) == 0;
        wr_en = $urandom; rd_en = $urandom; ser_en = $urandom; ser_in = $urandom;
        pdata_in = DATA_W'($urandom);
        tick();
      end
      idle();
    end
    tick(3);
    finish_run();
  end
endmodule